// File: doc/BRIEF.md
# SPI Register Access Master

This block runs single-register transactions on an external peripheral controller over a four-wire, full-duplex SPI link. A requester gives a 5-bit register number, a direction flag and, for writes, one data byte. The block then runs one two-byte frame. The first byte is a command that carries the register number and the direction. The second byte is the write value for a write, or zero for a read. While the command byte goes out, the peripheral sends back a status byte. While the second byte goes out, it sends back the register contents.

When the frame has finished and the select guard interval has passed, the block pulses `done` for one cycle. On that same cycle it presents the status byte and the second received byte. The serial clock idles low. Data changes while the clock is low and is captured on the rising edge. Three parameters set the lead time from select to the first edge, the length of each clock phase, and the minimum time the select stays high between frames. All three are counted in system clocks.

Top module: `spi_regport_master`

## Requirements
- R1: The command byte is the register number in bits 7:3, bit 1 set to 1 for a write and 0 for a read, and bits 2 and 0 zero.
- R2: Each byte is sent most significant bit first. MOSI changes only while SCLK is low and is stable across each rising edge. MISO is captured on each rising SCLK edge.
- R3: While no frame is active, and after reset, the select is high and SCLK and MOSI are low.
- R4: The select stays low for the whole frame, during which exactly 16 rising SCLK edges occur. The select rises together with the last falling SCLK edge.
- R5: The byte captured during the command byte is returned on `rsp_status`, for reads and writes alike.
- R6: For a read, the second byte sent is 0x00, and the byte captured during it is returned on `rsp_rdata`.
- R7: For a write, the second byte sent is the requested write value.
- R8: After the select rises it stays high for at least GUARD_CYC cycles before `done` is pulsed and before any new frame begins.
- R9: The first rising SCLK edge comes LEAD_CYC cycles after the select falls. Every later SCLK high phase and low phase lasts DIV_CYC cycles.
- R10: A request is taken only while `busy` is low. Requests made while `busy` is high have no effect. `done` is a one-cycle pulse, and `busy` is low from that cycle on.
- R11: The result is reported LEAD_CYC + 31*DIV_CYC + GUARD_CYC cycles after the request is taken. A request presented on the cycle after `done` starts the next frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 5 | Register number |
| req_wdata | input | 8 | Value to write |
| busy | output | 1 | Frame or guard interval in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 8 | Byte received during the command byte |
| rsp_rdata | output | 8 | Byte received during the second byte |
| spi_cs_n | output | 1 | Active-low peripheral select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
Once a request is taken, every pin has a fixed value at each cycle offset. The select falls on the next edge. The SCLK rise for bit i lands at offset LEAD_CYC + 2*i*DIV_CYC. The select rises at LEAD_CYC + 31*DIV_CYC, and `done`, with both response bytes, arrives at that offset plus GUARD_CYC. The bench keeps a cycle offset that starts when the request is taken, works out the expected select, SCLK, MOSI, busy and done levels from that offset, and compares them half a cycle after every edge. It answers MISO from the rising edges it has counted, so the returned bytes are known before `done` arrives. Back-to-back requests issued on the cycle after `done` exercise the shortest guard gap.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int ADDR_W  = 5;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_GUARD
  } xfer_state_t;

  // register number in 7:3, write flag in bit 1
  function automatic logic [BYTE_W-1:0] make_cmd(input logic [ADDR_W-1:0] addr,
                                                 input logic wr);
    return {addr, 1'b0, wr, 1'b0};
  endfunction

  function automatic int span_width(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return (m < 2) ? 1 : $clog2(m);
  endfunction
endpackage

// File: rtl/spi_regport_tick.sv
module spi_regport_tick #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/spi_regport_shreg.sv
module spi_regport_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         adv,
  input  logic         sample,
  input  logic         miso,
  output logic         next_bit,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)
        tx_q <= load_word;
      else if (adv)
        tx_q <= {tx_q[W-2:0], 1'b0};
      if (load)
        rx_q <= '0;
      else if (sample)
        rx_q <= {rx_q[W-2:0], miso};
    end
  end

  assign next_bit = tx_q[W-2];
  assign rx_word  = rx_q;
endmodule

// File: rtl/spi_regport_master.sv
module spi_regport_master
  import spi_regport_pkg::*;
#(
  parameter int DIV_CYC   = 2,
  parameter int LEAD_CYC  = 2,
  parameter int GUARD_CYC = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rsp_status,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int TW = span_width(DIV_CYC, LEAD_CYC, GUARD_CYC);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [TW-1:0] LEAD_LD  = TW'(LEAD_CYC - 1);
  localparam logic [TW-1:0] DIV_LD   = TW'(DIV_CYC - 1);
  localparam logic [TW-1:0] GUARD_LD = TW'(GUARD_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  xfer_state_t state;
  logic [BW-1:0] bit_idx;
  logic          tmr_exp;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          sh_next;
  logic [FRAME_W-1:0] rx_word;
  logic [FRAME_W-1:0] tx_word;

  logic accept, lead_end, hi_end, lo_end, guard_end, last_bit;

  always_comb begin
    accept    = (state == ST_IDLE) && req_valid;
    lead_end  = (state == ST_LEAD) && tmr_exp;
    hi_end    = (state == ST_HIGH) && tmr_exp;
    lo_end    = (state == ST_LOW) && tmr_exp;
    guard_end = (state == ST_GUARD) && tmr_exp;
    last_bit  = (bit_idx == LAST_BIT);
    tmr_load  = accept | lead_end | hi_end | lo_end;
    if (accept)
      tmr_val = LEAD_LD;
    else if (hi_end && last_bit)
      tmr_val = GUARD_LD;
    else
      tmr_val = DIV_LD;
    tx_word = {make_cmd(req_addr, req_write),
               req_write ? req_wdata : {BYTE_W{1'b0}}};
  end

  spi_regport_tick #(.W(TW)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  spi_regport_shreg #(.W(FRAME_W)) u_shreg (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_word (tx_word),
    .adv       (hi_end && !last_bit),
    .sample    (lead_end | lo_end),
    .miso      (spi_miso),
    .next_bit  (sh_next),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_idx    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      rsp_status <= '0;
      rsp_rdata  <= '0;
      spi_cs_n   <= 1'b1;
      spi_sclk   <= 1'b0;
      spi_mosi   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state    <= ST_LEAD;
            busy     <= 1'b1;
            spi_cs_n <= 1'b0;
            spi_mosi <= tx_word[FRAME_W-1];
            bit_idx  <= '0;
          end
        end
        ST_LEAD: begin
          if (tmr_exp) begin
            state    <= ST_HIGH;
            spi_sclk <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (tmr_exp) begin
            spi_sclk <= 1'b0;
            if (last_bit) begin
              state    <= ST_GUARD;
              spi_cs_n <= 1'b1;
              spi_mosi <= 1'b0;
            end else begin
              state    <= ST_LOW;
              spi_mosi <= sh_next;
              bit_idx  <= bit_idx + 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (tmr_exp) begin
            state    <= ST_HIGH;
            spi_sclk <= 1'b1;
          end
        end
        ST_GUARD: begin
          if (guard_end) begin
            state      <= ST_IDLE;
            busy       <= 1'b0;
            done       <= 1'b1;
            rsp_status <= rx_word[FRAME_W-1:BYTE_W];
            rsp_rdata  <= rx_word[BYTE_W-1:0];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_regport_checker.sv
module spi_regport_checker #(
  parameter int DIV_CYC   = 2,
  parameter int GUARD_CYC = 10
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi
);
  logic        sclk_q;
  logic [15:0] phase_cnt;
  logic [15:0] rise_cnt;
  logic [15:0] high_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      phase_cnt <= '0;
      rise_cnt  <= '0;
      high_cnt  <= 16'(GUARD_CYC);
    end else begin
      sclk_q <= spi_sclk;
      if (spi_sclk != sclk_q)
        phase_cnt <= 16'd1;
      else if (phase_cnt != 16'hFFFF)
        phase_cnt <= phase_cnt + 1'b1;
      if (spi_cs_n)
        rise_cnt <= '0;
      else if (spi_sclk && !sclk_q)
        rise_cnt <= rise_cnt + 1'b1;
      if (!spi_cs_n)
        high_cnt <= '0;
      else if (high_cnt < 16'(GUARD_CYC))
        high_cnt <= high_cnt + 1'b1;
    end
  end

  // R3: idle levels whenever the select is released
  a_r3_idle_pins: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> (!spi_sclk && !spi_mosi));

  // R2: MOSI only moves while SCLK is low
  a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && sclk_q) |-> $stable(spi_mosi));

  // R4: sixteen rising edges inside each select window
  a_r4_edge_count: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> (rise_cnt == 16'd16));

  // R9: each high phase lasts DIV_CYC cycles
  a_r9_high_phase: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && !spi_sclk) |-> (phase_cnt == 16'(DIV_CYC)));

  // R9: each low phase between bits lasts DIV_CYC cycles
  a_r9_low_phase: assert property (@(posedge clk) disable iff (rst)
    (!sclk_q && spi_sclk && rise_cnt != 16'd0) |-> (phase_cnt == 16'(DIV_CYC)));

  // R8: select held high for the guard interval before a new frame
  a_r8_guard_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (high_cnt >= 16'(GUARD_CYC)));

  // R10: done is a single-cycle pulse and coincides with busy low
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind spi_regport_master spi_regport_checker #(
  .DIV_CYC   (DIV_CYC),
  .GUARD_CYC (GUARD_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi)
);

// File: tb/spi_regport_master_tb.sv
module spi_regport_master_tb;
  localparam int DIV   = 2;
  localparam int LEAD  = 3;
  localparam int GUARD = 4;
  localparam int CS_END = LEAD + 31 * DIV;
  localparam int TEND   = CS_END + GUARD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic busy, done, spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;
  logic [7:0] rsp_status, rsp_rdata;

  logic [7:0] peer_status = '0;
  logic [7:0] peer_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int t        = -1;
  int rises    = 0;
  int n_done   = 0;
  int n_accept = 0;
  logic [15:0] m_frame = '0;
  logic [15:0] m_resp  = '0;
  logic [15:0] seen_mosi = '0;
  logic        sclk_prev = 1'b0;

  always #10 clk = ~clk;

  spi_regport_master #(.DIV_CYC(DIV), .LEAD_CYC(LEAD), .GUARD_CYC(GUARD)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .busy       (busy),
    .done       (done),
    .rsp_status (rsp_status),
    .rsp_rdata  (rsp_rdata),
    .spi_cs_n   (spi_cs_n),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  // reference offset model, advanced on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      t = -1;
    end else if ((t < 0 || t == TEND) && req_valid) begin
      t = 0;
      n_accept++;
      m_frame = {req_addr, 1'b0, req_write, 1'b0, req_write ? req_wdata : 8'h00};
      m_resp  = {peer_status, peer_rdata};
    end else if (t == TEND) begin
      t = -1;
    end else if (t >= 0) begin
      t++;
    end
  end

  // compare half a cycle after every edge, then act as the peripheral
  always @(negedge clk) begin
    if (!rst) begin
      bit e_cs, e_sclk, e_mosi, e_busy, e_done;
      int idx;
      if (t < 0) begin
        e_cs = 1; e_sclk = 0; e_mosi = 0; e_busy = 0; e_done = 0;
      end else begin
        e_cs   = (t >= CS_END);
        e_sclk = (t >= LEAD) && (t < CS_END) && (((t - LEAD) / DIV) % 2 == 0);
        idx    = (t < LEAD) ? 0 : (t - LEAD + DIV) / (2 * DIV);
        e_mosi = (t >= CS_END) ? 1'b0 : m_frame[15 - idx];
        e_busy = (t < TEND);
        e_done = (t == TEND);
      end
      check(spi_cs_n == e_cs, "R4/R3 select level", spi_cs_n, e_cs);
      check(spi_sclk == e_sclk, "R9 sclk level", spi_sclk, e_sclk);
      check(spi_mosi == e_mosi, "R2 mosi bit", spi_mosi, e_mosi);
      check(busy == e_busy, "R10 busy level", busy, e_busy);
      check(done == e_done, "R11 done timing", done, e_done);

      if (t == 0) begin
        rises = 0;
        seen_mosi = '0;
      end
      if (spi_sclk && !sclk_prev && !spi_cs_n) begin
        seen_mosi = {seen_mosi[14:0], spi_mosi};
        rises++;
      end
      sclk_prev = spi_sclk;
      spi_miso = (t >= 0 && rises < 16) ? m_resp[15 - rises] : 1'b0;

      if (done) begin
        n_done++;
        check(seen_mosi[15:8] == m_frame[15:8], "R1 command byte", seen_mosi[15:8], m_frame[15:8]);
        check(seen_mosi[7:0] == m_frame[7:0], "R6/R7 second byte", seen_mosi[7:0], m_frame[7:0]);
        check(rises == 16, "R4 rising edge count", rises, 16);
        check(rsp_status == m_resp[15:8], "R5 status byte", rsp_status, m_resp[15:8]);
        check(rsp_rdata == m_resp[7:0], "R6 read byte", rsp_rdata, m_resp[7:0]);
      end
    end
  end

  task automatic run_txn(input bit wr, input logic [4:0] a, input logic [7:0] wd,
                         input logic [7:0] st, input logic [7:0] rd);
    peer_status = st;
    peer_rdata  = rd;
    req_write   = wr;
    req_addr    = a;
    req_wdata   = wd;
    req_valid   = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3: reset state
    check(spi_cs_n == 1'b1, "R3 reset select", spi_cs_n, 1);
    check(spi_sclk == 1'b0 && spi_mosi == 1'b0, "R3 reset sclk/mosi", {spi_sclk, spi_mosi}, 0);
    check(busy == 1'b0 && done == 1'b0, "R10 reset busy/done", {busy, done}, 0);

    // R7 R5: write
    run_txn(1'b1, 5'h11, 8'hA5, 8'h3C, 8'h96);
    // R6 R11: back-to-back read on the cycle after done (minimum guard, R8)
    run_txn(1'b0, 5'h12, 8'hFF, 8'h81, 8'h5E);
    // R1: highest and lowest register numbers
    run_txn(1'b0, 5'h1F, 8'h00, 8'hFF, 8'h00);
    run_txn(1'b1, 5'h00, 8'hFF, 8'h00, 8'hFF);
    run_txn(1'b1, 5'h0A, 8'h01, 8'h80, 8'h7F);

    // R10: a request while busy must be ignored
    fork
      run_txn(1'b0, 5'h05, 8'h00, 8'h55, 8'hAA);
      begin
        repeat (20) @(negedge clk);
        req_write = 1'b1;
        req_addr  = 5'h1B;
        req_wdata = 8'hC3;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (TEND + 5) @(negedge clk);
    check(n_done == 6, "R10 done count after ignored request", n_done, 6);
    check(n_accept == 6, "R10 accepted request count", n_accept, 6);
    check(spi_cs_n == 1'b1 && busy == 1'b0, "R3 idle after run", {spi_cs_n, busy}, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule